// File: doc/BRIEF.md
# Dual-Copy Registered Command Buffer with Parity Check

This block registers a 28-bit command/address word from a memory controller on each rising clock edge. It drives the captured word onto two identical output copies, a 1:2 fan-out, so that one controller net can feed two loads on a dense memory module. The copies update only while at least one of the chip-select inputs is asserted (low). When every select is high, both copies keep their last value, so the wide output buses do not toggle.

Alongside the data path, an odd-parity checker covers the low 22 bits of each captured word. The controller sends the matching parity bit one cycle after the word. A mismatch drives an active-low error flag for at least two clock cycles. The result of the parity sum is also brought out on a registered parity-out pin. Parity is checked whether or not the block is selected.

Top module: `regfan_buf`

## Requirements
- R1: After every rising edge, `qa` and `qb` carry the same 28-bit value.
- R2: When at least one bit of `cs_n` is 0 at a rising edge, `qa` and `qb` equal the `d` sampled at that edge once the edge has passed.
- R3: When all bits of `cs_n` are 1 at a rising edge, `qa` and `qb` keep the value they had before that edge.
- R4: Each of the four select inputs enables the outputs on its own when it is the only one at 0. With the two extra selects, bits 2 and 3, held at 1, the block behaves as a two-select register.
- R5: The parity sum covers `d[21:0]` of the word captured at edge k, together with `par_in` sampled at edge k+1. Bits `d[27:22]` never affect parity.
- R6: If the parity sum from R5 is even, `err_n` is 0 after edge k+2. If it is odd and no earlier error is still being held, `err_n` is 1.
- R7: Once `err_n` falls it stays 0 for at least two cycles. A further mismatch restarts the two-cycle hold.
- R8: After edge k+1, `par_out` equals the XOR of `d[21:0]` from edge k and `par_in` from edge k+1. A value of 1 means the check passed.
- R9: Parity checking and the error flag work the same way while every select is deasserted.
- R10: A rising edge with `rst` at 1 clears `qa`, `qb`, `par_out` and the captured parity word to zero, and sets `err_n` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| d | input | 28 | Command/address word from the controller |
| par_in | input | 1 | Odd-parity bit for the previous cycle's word |
| cs_n | input | 4 | Chip selects, active low; bits 2 and 3 are the extra pair |
| qa | output | 28 | Registered output copy A |
| qb | output | 28 | Registered output copy B |
| par_out | output | 1 | Registered parity sum (1 = odd, correct) |
| err_n | output | 1 | Parity error flag, active low, held for at least two cycles |

## Verification
The assertions assume that `rst` is held high on the first clock edges, so that no property looks at undefined state. They also assume that `par_in` always refers to the word captured one edge earlier. The stimulus follows this. It asserts reset from time zero. It then derives each parity bit from the word it drove one cycle before, and only inverts that bit on purpose to inject an error. Select patterns, injected errors and changes in the uncovered high bits are mixed across the run. This covers back-to-back errors and errors that arrive while the block is deselected.

// File: rtl/regfan_pkg.sv
package regfan_pkg;
    localparam int DATA_W     = 28;
    localparam int PAR_W      = 22;
    localparam int NUM_CS     = 4;
    localparam int NUM_COPIES = 2;
    localparam int ERR_HOLD   = 2;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic mismatch;
        logic sum;
    } par_res_t;

    // odd parity sum over covered bits plus the controller bit
    function automatic logic odd_sum(input word_t w, input logic p);
        return (^w[PAR_W-1:0]) ^ p;
    endfunction
endpackage

// File: rtl/regfan_capture.sv
module regfan_capture
    import regfan_pkg::*;
#(
    parameter int W      = DATA_W,
    parameter int CS_W   = NUM_CS,
    parameter int COPIES = NUM_COPIES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [W-1:0]        d,
    input  logic [CS_W-1:0]     cs_n,
    output logic [COPIES*W-1:0] q_flat
);
    logic hold;
    assign hold = &cs_n;

    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        logic [W-1:0] q_r;
        always_ff @(posedge clk) begin
            if (rst)        q_r <= '0;
            else if (!hold) q_r <= d;
        end
        assign q_flat[c*W +: W] = q_r;
    end

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(q_flat));
    // R2
    load_chk: assert property (@(posedge clk) disable iff (rst)
        !hold |=> (q_flat[W-1:0] == $past(d)));
endmodule

// File: rtl/regfan_parity.sv
module regfan_parity
    import regfan_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t d,
    input  logic  par_in,
    output logic  perr,
    output logic  par_out
);
    word_t    dcap;
    par_res_t res_r;
    par_res_t res_n;

    always_comb begin
        res_n.sum      = odd_sum(dcap, par_in);
        res_n.mismatch = ~res_n.sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dcap  <= '0;
            res_r <= '0;
        end else begin
            dcap  <= d;
            res_r <= res_n;
        end
    end

    assign perr    = res_r.mismatch;
    assign par_out = res_r.sum;
endmodule

// File: rtl/regfan_errflag.sv
module regfan_errflag
    import regfan_pkg::*;
#(
    parameter int HOLD = ERR_HOLD
) (
    input  logic clk,
    input  logic rst,
    input  logic perr,
    output logic err_n
);
    localparam int CW = $clog2(HOLD + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (perr)         cnt <= CW'(HOLD);
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign err_n = (cnt == '0);

    // R6
    err_follow_chk: assert property (@(posedge clk) disable iff (rst)
        perr |=> !err_n);
    // R7
    err_min_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(err_n) |=> !err_n);
endmodule

// File: rtl/regfan_buf.sv
module regfan_buf
    import regfan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] d,
    input  logic              par_in,
    input  logic [NUM_CS-1:0] cs_n,
    output logic [DATA_W-1:0] qa,
    output logic [DATA_W-1:0] qb,
    output logic              par_out,
    output logic              err_n
);
    logic [NUM_COPIES*DATA_W-1:0] q_flat;
    logic                         perr;

    regfan_capture #(.W(DATA_W), .CS_W(NUM_CS), .COPIES(NUM_COPIES)) i_cap (
        .clk(clk), .rst(rst), .d(d), .cs_n(cs_n), .q_flat(q_flat)
    );

    regfan_parity i_par (
        .clk(clk), .rst(rst), .d(d), .par_in(par_in),
        .perr(perr), .par_out(par_out)
    );

    regfan_errflag #(.HOLD(ERR_HOLD)) i_err (
        .clk(clk), .rst(rst), .perr(perr), .err_n(err_n)
    );

    assign qa = q_flat[0 +: DATA_W];
    assign qb = q_flat[DATA_W +: DATA_W];

    // R1
    copies_match_chk: assert property (@(posedge clk) disable iff (rst)
        qa == qb);
    // R10
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (err_n && !par_out && qa == '0 && qb == '0));
endmodule

// File: tb/test_regfan_buf.sv
module test_regfan_buf;
    localparam int W = 28, CS = 4, PW = 22;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  d = '0;
    logic [CS-1:0] cs_n = '1;
    logic          par_in = 1'b1;
    logic [W-1:0]  qa, qb;
    logic          par_out, err_n;

    int n_run = 0, n_fail = 0;

    logic [W-1:0] m_q = '0, m_prev = '0;
    logic         m_perr = 0, m_pout = 0;
    int           m_cnt = 0;

    regfan_buf i_regfan_buf (
        .clk(clk), .rst(rst), .d(d), .par_in(par_in), .cs_n(cs_n),
        .qa(qa), .qb(qb), .par_out(par_out), .err_n(err_n)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic good_p();
        return ~(^m_prev[PW-1:0]);
    endfunction

    // called at a negedge; drives, models the next edge, compares at the following negedge
    task automatic step(input logic r, input logic [W-1:0] dv, input logic [CS-1:0] cv,
                        input logic p, input string qtag, input string etag);
        logic pp;
        rst = r; d = dv; cs_n = cv; par_in = p;
        @(posedge clk);
        if (r) begin
            m_q = '0; m_prev = '0; m_perr = 0; m_pout = 0; m_cnt = 0;
        end else begin
            m_cnt  = m_perr ? 2 : (m_cnt > 0 ? m_cnt - 1 : 0);
            pp     = (^m_prev[PW-1:0]) ^ p;
            m_perr = !pp;
            m_pout = pp;
            m_prev = dv;
            if (!(&cv)) m_q = dv;
        end
        @(negedge clk);
        chk({qtag, " qa"}, qa, m_q);
        chk({"R1 qb", " ", qtag}, qb, m_q);
        chk({etag, " err_n"}, W'(err_n), W'(m_cnt == 0));
        chk("R8 par_out", W'(par_out), W'(m_pout));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0]  rd;
        logic [CS-1:0] rc;
        @(negedge clk);
        // R10 reset state
        for (int i = 0; i < 3; i++) step(1, W'($urandom), 4'b0000, 0, "R10", "R10");
        // R2 / R3 random traffic, good parity
        for (int i = 0; i < 60; i++) begin
            rd = W'($urandom); rc = CS'($urandom);
            step(0, rd, rc, good_p(), (&rc) ? "R3" : "R2", "R6");
        end
        // R4 each select alone, extra pair high
        for (int c = 0; c < CS; c++)
            for (int i = 0; i < 4; i++)
                step(0, W'($urandom), ~(CS'(1) << c), good_p(), "R4", "R6");
        step(0, 28'h1234567, 4'b1100, good_p(), "R4", "R6");
        step(0, 28'h7654321, 4'b1111, good_p(), "R3", "R6");
        // R5 uncovered high bits only; parity stays correct
        for (int i = 0; i < 8; i++)
            step(0, {6'($urandom), 22'h0}, 4'b1110, good_p(), "R2", "R5");
        // R6 single injected errors
        for (int i = 0; i < 4; i++) begin
            step(0, W'($urandom), 4'b1101, ~good_p(), "R2", "R6");
            for (int j = 0; j < 5; j++)
                step(0, W'($urandom), 4'b1101, good_p(), "R2", "R6 R7");
        end
        // R7 back-to-back errors restart hold
        for (int i = 0; i < 3; i++)
            step(0, W'($urandom), 4'b0111, ~good_p(), "R2", "R7");
        for (int j = 0; j < 5; j++)
            step(0, W'($urandom), 4'b0111, good_p(), "R2", "R7");
        // R9 errors while deselected
        for (int i = 0; i < 20; i++) begin
            rd = W'($urandom);
            step(0, rd, 4'b1111, (i % 3 == 0) ? ~good_p() : good_p(), "R3", "R9");
        end
        // R10 reset mid-stream
        step(0, W'($urandom), 4'b0000, ~good_p(), "R2", "R6");
        step(1, W'($urandom), 4'b0000, 0, "R10", "R10");
        step(0, W'($urandom), 4'b0000, good_p(), "R2", "R10");
        for (int i = 0; i < 4; i++) step(0, W'($urandom), 4'b1011, good_p(), "R2", "R6");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule